// File: doc/BRIEF.md
# Eight-Byte Maximum Reduction Unit

This block finds the largest unsigned byte in a window of eight neighbouring memory bytes and hands it to the accumulator. A single start strobe comes with an 8-bit base address. The unit presents eight lane addresses, base plus 0 through base plus 7, to a multi-ported read path and takes back eight data bytes at the same time.

The bytes run through a cascade of eight compare-and-select stages. The cascade starts from a zero seed, and each stage passes on the larger of its incoming running value and its own lane byte. At the next clock edge the cascade output overwrites the accumulator copy. A one-cycle accumulator write enable and a one-cycle done pulse go out at the same time. The unit only reads memory and has no write path into it.

Top module: `byte_max8`

## Requirements
- R1: Lane address i (bits 8i+7 down to 8i of `lane_addr_o`) equals `base_i + i` modulo 256 for i = 0..7, so a window that starts at FCh covers FCh..FFh and then 00h..03h.
- R2: In the cycle after a cycle with `start_i` high, `result_o` holds the largest of the eight lane bytes that were sampled in the start cycle (lane i on bits 8i+7 down to 8i of `lane_data_i`).
- R3: The cascade seed is 00h, so a window of all-zero bytes gives a result of 00h.
- R4: Bytes compare as unsigned numbers, so 80h is larger than 7Fh.
- R5: `acc_we_o` and `done_o` are high for exactly the one cycle after each cycle with `start_i` high. A start held high on consecutive cycles gives one result per cycle, each one from its own base.
- R6: A new result replaces the earlier accumulator contents even when the new value is smaller.
- R7: While `start_i` is low, `result_o` does not change and `done_o` and `acc_we_o` stay low in the following cycle.
- R8: Synchronous active-high reset clears `result_o` to 00h and drives `done_o` and `acc_we_o` low.
- R9: The result does not depend on the lane that holds the maximum. A maximum in lane 0, in lane 7, or in every lane at once (all bytes equal) gives that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts one reduction in this cycle |
| base_i | input | 8 | Address of the first byte of the window |
| lane_addr_o | output | 64 | Eight lane read addresses, lane 0 in the low byte |
| lane_data_i | input | 64 | Eight lane read bytes, lane 0 in the low byte |
| result_o | output | 8 | Accumulator copy holding the latest maximum |
| acc_we_o | output | 1 | Accumulator write strobe, one cycle after start |
| done_o | output | 1 | Completion pulse, one cycle after start |

## Verification
A table of windows drives the main function. The first is a mixed window whose maximum sits in a middle lane. The others are an all-zero window that exposes the seed, a 7Fh/80h pair that separates unsigned from signed comparison, a window that wraps past FFh and puts its maximum in the last lane, a window with its maximum in lane 0, and a window of equal bytes. A small window placed after a large one shows that the old accumulator value is dropped. Directed tests cover reset, back-to-back starts with different bases, and idle cycles in which the result must hold.

// File: rtl/bm8_pkg.sv
package bm8_pkg;

    localparam int unsigned BM8_LANES  = 8;
    localparam int unsigned BM8_DATA_W = 8;
    localparam int unsigned BM8_ADDR_W = 8;

    typedef logic [BM8_DATA_W-1:0] bm8_byte_t;

    // Registered state of the accumulator side of the unit.
    typedef struct packed {
        bm8_byte_t value;
        logic      wr_en;
        logic      done;
    } bm8_acc_t;

    localparam bm8_acc_t BM8_ACC_RESET = '{value: '0, wr_en: 1'b0, done: 1'b0};

    // Unsigned pick of the larger byte; on a tie the running value wins.
    function automatic bm8_byte_t bm8_pick(input bm8_byte_t running, input bm8_byte_t lane);
        return (lane > running) ? lane : running;
    endfunction

endpackage

// File: rtl/bm8_lane_addr.sv
module bm8_lane_addr #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]       base_i,
    output logic [LANES*ADDR_W-1:0] addr_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Natural width truncation gives the modulo wrap.
        assign addr_o[g*ADDR_W +: ADDR_W] = base_i + ADDR_W'(g);
    end

endmodule

// File: rtl/bm8_stage.sv
module bm8_stage
    import bm8_pkg::*;
(
    input  bm8_byte_t prev_i,
    input  bm8_byte_t lane_i,
    output bm8_byte_t max_o
);

    always_comb begin
        max_o = bm8_pick(prev_i, lane_i);
    end

endmodule

// File: rtl/bm8_acc_reg.sv
module bm8_acc_reg
    import bm8_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  bm8_byte_t value_i,
    output bm8_acc_t  acc_o
);

    bm8_acc_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= BM8_ACC_RESET;
        end else begin
            acc_q.wr_en <= load_i;
            acc_q.done  <= load_i;
            if (load_i) begin
                acc_q.value <= value_i;
            end
        end
    end

    assign acc_o = acc_q;

    // R7: with no start, the held value does not move.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(acc_q.value));

    // R5: every start yields a write strobe on the next cycle.
    p_we_after_start_r5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> acc_q.wr_en);

endmodule

// File: rtl/byte_max8.sv
module byte_max8
    import bm8_pkg::*;
#(
    parameter int unsigned LANES  = BM8_LANES,
    parameter int unsigned ADDR_W = BM8_ADDR_W,
    parameter int unsigned DATA_W = BM8_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    output logic [LANES*ADDR_W-1:0]  lane_addr_o,
    input  logic [LANES*DATA_W-1:0]  lane_data_i,
    output logic [DATA_W-1:0]        result_o,
    output logic                     acc_we_o,
    output logic                     done_o
);

    localparam int unsigned CHAIN_LEN = LANES + 1;

    bm8_byte_t running [CHAIN_LEN];
    bm8_acc_t  acc;

    bm8_lane_addr #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base_i (base_i),
        .addr_o (lane_addr_o)
    );

    // Zero seed at the head of the cascade (R3).
    assign running[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_stage
        bm8_stage u_stage (
            .prev_i (running[g]),
            .lane_i (lane_data_i[g*DATA_W +: DATA_W]),
            .max_o  (running[g+1])
        );

        // R2: no stage loses a value it has already seen.
        p_stage_monotone_r2: assert property (@(posedge clk) disable iff (rst)
            (running[g+1] >= running[g]) && (running[g+1] >= lane_data_i[g*DATA_W +: DATA_W]));
    end

    bm8_acc_reg u_acc (
        .clk     (clk),
        .rst     (rst),
        .load_i  (start_i),
        .value_i (running[LANES]),
        .acc_o   (acc)
    );

    assign result_o = acc.value;
    assign acc_we_o = acc.wr_en;
    assign done_o   = acc.done;

    // R1: neighbouring lanes are one address apart, modulo the address width.
    for (genvar g = 1; g < LANES; g++) begin : g_addr_chk
        p_lane_step_r1: assert property (@(posedge clk) disable iff (rst)
            lane_addr_o[g*ADDR_W +: ADDR_W] == ADDR_W'(lane_addr_o[(g-1)*ADDR_W +: ADDR_W] + 1'b1));
    end

    // R5: done follows a start by exactly one cycle.
    p_done_after_start_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R7: no completion without a start.
    p_no_spurious_done_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o && !acc_we_o);

    // R2: the captured result equals the cascade output of the start cycle.
    p_result_capture_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> result_o == $past(running[LANES]));

endmodule

// File: tb/byte_max8_test.sv
module byte_max8_test;

    localparam int NVEC = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  base_i = 8'h00;
    logic [63:0] lane_addr_o;
    logic [63:0] lane_data_i;
    logic [7:0]  result_o;
    logic        acc_we_o;
    logic        done_o;

    logic [7:0] ram [256];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Window table: base, eight bytes (lane 0 lowest), expected maximum.
    localparam logic [7:0]  VBASE [NVEC] = '{8'h20, 8'h00, 8'h40, 8'hFC, 8'h80, 8'h10, 8'h33};
    localparam logic [63:0] VDATA [NVEC] = '{
        64'h66_55_A6_F4_C2_E2_E1_04,   // R2 mixed window
        64'h00_00_00_00_00_00_00_00,   // R3 zero seed
        64'h01_02_03_04_05_06_80_7F,   // R4 unsigned
        64'hFF_70_60_50_40_30_20_10,   // R1 wrap, R9 last lane
        64'h00_00_00_00_00_00_00_FF,   // R9 first lane
        64'h5A_5A_5A_5A_5A_5A_5A_5A,   // R9 all equal
        64'h08_07_06_05_04_03_02_01    // R6 smaller than before
    };
    localparam logic [7:0]  VEXP [NVEC] = '{8'hF4, 8'h00, 8'h80, 8'hFF, 8'hFF, 8'h5A, 8'h08};

    always #4 clk = ~clk;

    byte_max8 uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .base_i      (base_i),
        .lane_addr_o (lane_addr_o),
        .lane_data_i (lane_data_i),
        .result_o    (result_o),
        .acc_we_o    (acc_we_o),
        .done_o      (done_o)
    );

    // Multi-ported read model.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            lane_data_i[i*8 +: 8] = ram[lane_addr_o[i*8 +: 8]];
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_window(input logic [7:0] base, input logic [63:0] bytes);
        for (int i = 0; i < 8; i++) begin
            ram[8'(base + 8'(i))] = bytes[i*8 +: 8];
        end
    endtask

    function automatic logic [63:0] exp_addrs(input logic [7:0] base);
        logic [63:0] a;
        for (int i = 0; i < 8; i++) a[i*8 +: 8] = 8'(base + 8'(i));
        return a;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 result", 64'(result_o), 64'h00);
        check("R8 done", 64'(done_o), 64'h0);
        check("R8 acc_we", 64'(acc_we_o), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            load_window(VBASE[v], VDATA[v]);
            base_i  = VBASE[v];
            start_i = 1'b1;
            #1;
            check("R1 lane addresses", lane_addr_o, exp_addrs(VBASE[v]));
            @(negedge clk);
            start_i = 1'b0;
            check("R2 R3 R4 R6 R9 result", 64'(result_o), 64'(VEXP[v]));
            check("R5 done pulse", 64'(done_o), 64'h1);
            check("R5 acc_we pulse", 64'(acc_we_o), 64'h1);
            @(negedge clk);
            check("R5 done single cycle", 64'({done_o, acc_we_o}), 64'h0);
        end

        // R7 idle cycles: change base, no start, result holds
        base_i = 8'h20;
        repeat (3) @(negedge clk);
        check("R7 result held", 64'(result_o), 64'h08);
        check("R7 no done", 64'({done_o, acc_we_o}), 64'h0);

        // R5 back-to-back starts with different bases
        base_i  = 8'h20;
        start_i = 1'b1;
        @(negedge clk);
        check("R5 b2b first", 64'(result_o), 64'hF4);
        check("R5 b2b first done", 64'(done_o), 64'h1);
        base_i = 8'h33;
        @(negedge clk);
        start_i = 1'b0;
        check("R5 b2b second", 64'(result_o), 64'h08);
        check("R5 b2b second done", 64'(done_o), 64'h1);
        @(negedge clk);
        check("R5 b2b done ends", 64'(done_o), 64'h0);

        // R8 reset clears the held result
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset result", 64'(result_o), 64'h00);
        rst = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule